// File: doc/BRIEF.md
# I/O Space Router

This block routes I/O-port requests to a destination node and link. It holds a set of programmable windows. Each window is a base register and a limit register, and each window names a destination node and link. On each request the block compares the I/O address with every window. It reports the destination of the winning window, or it raises a no-match flag when no window accepts the address.

Two legacy rules sit on top of the plain range compare, and each window turns them on separately:
- The display-adapter rule accepts the fixed monochrome and colour adapter port ranges in any 64 KB-low address, even when the window's range does not cover the address.
- The alias filter keeps the plain range compare from accepting the upper three quarters of every 1 KB block below 64 KB. This leaves the low 256 ports of each block for the window.

Software programs the windows through a small register port that it can also read back. Requests arrive with a valid strobe, an address and a direction flag. The response appears one clock later.

Top module: `io_space_router`

## Requirements
- R1: After reset every register reads as zero, every window is disabled, and `rsp_valid`, `rsp_hit` and `rsp_miss` are low.
- R2: `cfg_addr` bit 0 selects the limit register (1) or the base register (0), and the bits above it give the window index. Base layout: read enable at bit 0, write enable at bit 1, display-adapter enable at bit 4, alias-filter enable at bit 5, base window at [24:12]. Limit layout: node at [2:0], link at [5:4], limit window at [24:12]. All other bits are not stored and read as zero.
- R3: A limit write with link code 2'b11 leaves the stored link unchanged. The write still updates the node and the limit window.
- R4: The range compare accepts an address when address bits [24:12] lie between the base window and the limit window, with both ends included. This gives 4 KB granularity.
- R5: A window accepts a read only when its read enable is set, and a write only when its write enable is set. This applies to both range and display-adapter matches.
- R6: With the display-adapter enable set, an address below 0x10000 whose bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF matches the window, whatever its base and limit. Addresses at or above 0x10000 never match this way.
- R7: With the alias-filter enable set, an address below 0x10000 whose bits [9:8] are not 00 cannot match the window through the range compare.
- R8: The alias filter does not block a display-adapter match.
- R9: When several windows match, the lowest-numbered one wins. `rsp_pair`, `rsp_node` and `rsp_link` come from that window.
- R10: When no window matches a valid request, `rsp_miss` is high, `rsp_hit` is low, and node, link and pair read zero.
- R11: `rsp_valid` follows `req_valid` one clock later. A request in the same cycle as a register write uses the values from before the write. When `rsp_valid` is low, all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: window index and base/limit bit |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request direction: 1 write, 0 read |
| req_addr | input | 25 | I/O address of the request |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | A window accepted the request |
| rsp_miss | output | 1 | No window accepted the request |
| rsp_node | output | 3 | Destination node |
| rsp_link | output | 2 | Destination link |
| rsp_pair | output | 2 | Index of the winning window |

## Verification
The assertions check these properties on every cycle:
- the winning window has no lower-numbered window that also matches;
- a disabled access type never produces a match;
- the alias filter removes a range match when no display-adapter match rescues it;
- a stored link code never holds the reserved value;
- reserved read bits stay zero;
- a miss carries a zero destination, and responses keep their one-clock latency.

Only the bench scenarios can show that each window edge is inclusive, that the display-adapter port ranges end exactly where they should, and that a filtered address still reaches the window when its low 256-port slice is used. Those scenarios also show that a second window takes over once the first is disabled.

// File: rtl/iorr_pkg.sv
package iorr_pkg;

   localparam int REG_W  = 32;
   localparam int NODE_W = 3;
   localparam int LINK_W = 2;
   localparam int WIN_LO = 12;
   localparam int WIN_W  = 13;
   localparam int WIN_HI = WIN_LO + WIN_W - 1;

   localparam logic [LINK_W-1:0] LINK_RSVD = 2'b11;

   localparam logic [REG_W-1:0] BASE_MASK = 32'h01FF_F033;
   localparam logic [REG_W-1:0] LIM_MASK  = 32'h01FF_F037;

   typedef struct packed {
      logic             rd_en;
      logic             wr_en;
      logic             vga_en;
      logic             isa_en;
      logic [WIN_W-1:0] win;
   } base_t;

   typedef struct packed {
      logic [NODE_W-1:0] node;
      logic [LINK_W-1:0] link;
      logic [WIN_W-1:0]  win;
   } lim_t;

   function automatic logic [REG_W-1:0] pack_base(base_t b);
      logic [REG_W-1:0] r;
      r = '0;
      r[0] = b.rd_en;
      r[1] = b.wr_en;
      r[4] = b.vga_en;
      r[5] = b.isa_en;
      r[WIN_HI:WIN_LO] = b.win;
      return r;
   endfunction

   function automatic logic [REG_W-1:0] pack_lim(lim_t l);
      logic [REG_W-1:0] r;
      r = '0;
      r[NODE_W-1:0] = l.node;
      r[5:4] = l.link;
      r[WIN_HI:WIN_LO] = l.win;
      return r;
   endfunction

endpackage

// File: rtl/iorr_cfg_regs.sv
module iorr_cfg_regs #(
   parameter int NUM_PAIRS = 4,
   parameter int IDX_W     = 2
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W:0]             sel,
   input  logic [iorr_pkg::REG_W-1:0] wdata,
   output logic [iorr_pkg::REG_W-1:0] rdata,
   output iorr_pkg::base_t            base_q [NUM_PAIRS],
   output iorr_pkg::lim_t             lim_q  [NUM_PAIRS]
);
   import iorr_pkg::*;

   logic [IDX_W-1:0] pair_sel;
   logic             is_lim;
   logic             unused_wd;

   assign pair_sel  = sel[IDX_W:1];
   assign is_lim    = sel[0];
   assign unused_wd = ^{wdata[REG_W-1:WIN_HI+1], wdata[WIN_LO-1:6], wdata[3]};

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic hit_sel;
      assign hit_sel = wr_en && (pair_sel == IDX_W'(p));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[p] <= '0;
            lim_q[p]  <= '0;
         end else if (hit_sel) begin
            if (is_lim) begin
               lim_q[p].node <= wdata[NODE_W-1:0];
               lim_q[p].win  <= wdata[WIN_HI:WIN_LO];
               if (wdata[5:4] != LINK_RSVD)
                  lim_q[p].link <= wdata[5:4];
            end else begin
               base_q[p].rd_en  <= wdata[0];
               base_q[p].wr_en  <= wdata[1];
               base_q[p].vga_en <= wdata[4];
               base_q[p].isa_en <= wdata[5];
               base_q[p].win    <= wdata[WIN_HI:WIN_LO];
            end
         end
      end

      // R3
      link_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lim_q[p].link != LINK_RSVD);

      // R3
      link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_sel && is_lim && wdata[5:4] == LINK_RSVD) |=> $stable(lim_q[p].link));
   end

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NUM_PAIRS; p++) begin
         if (pair_sel == IDX_W'(p))
            rdata = is_lim ? pack_lim(lim_q[p]) : pack_base(base_q[p]);
      end
   end

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~(is_lim ? LIM_MASK : BASE_MASK)) == '0);

endmodule

// File: rtl/iorr_pair_match.sv
module iorr_pair_match #(
   parameter int ADDR_W = 25
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  iorr_pkg::base_t              cfg_base,
   input  logic [iorr_pkg::WIN_W-1:0]   cfg_lim,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic                         req_write,
   output logic                         hit
);
   import iorr_pkg::*;

   logic             low64k;
   logic             upper_ok;
   logic [9:0]       lo10;
   logic [WIN_W-1:0] win;
   logic             vga_win;
   logic             vga_hit;
   logic             isa_block;
   logic             range_hit;
   logic             access_ok;
   logic             unused_mid;

   assign lo10       = req_addr[9:0];
   assign win        = req_addr[WIN_HI:WIN_LO];
   assign low64k     = (req_addr[ADDR_W-1:16] == '0);
   assign unused_mid = ^req_addr[11:10];

   if (ADDR_W > WIN_HI + 1) begin : g_wide
      assign upper_ok = (req_addr[ADDR_W-1:WIN_HI+1] == '0);
   end else begin : g_exact
      assign upper_ok = 1'b1;
   end

   assign vga_win   = ((lo10 >= 10'h3B0) && (lo10 <= 10'h3BB)) ||
                      ((lo10 >= 10'h3C0) && (lo10 <= 10'h3DF));
   assign vga_hit   = cfg_base.vga_en && low64k && vga_win;
   assign isa_block = cfg_base.isa_en && low64k && (lo10[9:8] != 2'b00);
   assign range_hit = upper_ok && (win >= cfg_base.win) && (win <= cfg_lim);
   assign access_ok = req_write ? cfg_base.wr_en : cfg_base.rd_en;
   assign hit       = access_ok && (vga_hit || (range_hit && !isa_block));

   // R5
   access_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_write ? !cfg_base.wr_en : !cfg_base.rd_en) |-> !hit);

   // R7
   alias_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_base.isa_en && low64k && lo10[9:8] != 2'b00 && !vga_hit) |-> !hit);

endmodule

// File: rtl/iorr_pick.sv
module iorr_pick #(
   parameter int NUM_PAIRS = 4,
   parameter int IDX_W     = 2
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PAIRS-1:0]        hits,
   input  logic [iorr_pkg::NODE_W-1:0] node_i [NUM_PAIRS],
   input  logic [iorr_pkg::LINK_W-1:0] link_i [NUM_PAIRS],
   output logic                        any,
   output logic [IDX_W-1:0]            idx,
   output logic [iorr_pkg::NODE_W-1:0] node,
   output logic [iorr_pkg::LINK_W-1:0] link
);

   always_comb begin
      any  = 1'b0;
      idx  = '0;
      node = '0;
      link = '0;
      for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
         if (hits[p]) begin
            any  = 1'b1;
            idx  = IDX_W'(p);
            node = node_i[p];
            link = link_i[p];
         end
      end
   end

   // R9
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (hits[idx] && ((hits & ((NUM_PAIRS'(1) << idx) - NUM_PAIRS'(1))) == '0)));

endmodule

// File: rtl/io_space_router.sv
module io_space_router #(
   parameter int NUM_PAIRS = 4,
   parameter int ADDR_W    = 25,
   parameter bit REG_OUT   = 1'b1,
   localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [IDX_W:0]              cfg_addr,
   input  logic [iorr_pkg::REG_W-1:0]  cfg_wdata,
   output logic [iorr_pkg::REG_W-1:0]  cfg_rdata,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [ADDR_W-1:0]           req_addr,
   output logic                        rsp_valid,
   output logic                        rsp_hit,
   output logic                        rsp_miss,
   output logic [iorr_pkg::NODE_W-1:0] rsp_node,
   output logic [iorr_pkg::LINK_W-1:0] rsp_link,
   output logic [IDX_W-1:0]            rsp_pair
);
   import iorr_pkg::*;

   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("NUM_PAIRS must be at least 1");
   end
   if (ADDR_W < WIN_HI + 1) begin : g_bad_addr
      $error("ADDR_W must cover the window field");
   end

   base_t             base_q [NUM_PAIRS];
   lim_t              lim_q  [NUM_PAIRS];
   logic [NODE_W-1:0] node_a [NUM_PAIRS];
   logic [LINK_W-1:0] link_a [NUM_PAIRS];
   logic [NUM_PAIRS-1:0] hits;

   logic              any_d;
   logic [IDX_W-1:0]  idx_d;
   logic [NODE_W-1:0] node_d;
   logic [LINK_W-1:0] link_d;

   iorr_cfg_regs #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .sel    (cfg_addr),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .base_q (base_q),
      .lim_q  (lim_q)
   );

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_match
      assign node_a[p] = lim_q[p].node;
      assign link_a[p] = lim_q[p].link;

      iorr_pair_match #(.ADDR_W(ADDR_W)) u_match (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_base  (base_q[p]),
         .cfg_lim   (lim_q[p].win),
         .req_addr  (req_addr),
         .req_write (req_write),
         .hit       (hits[p])
      );
   end

   iorr_pick #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .hits   (hits),
      .node_i (node_a),
      .link_i (link_a),
      .any    (any_d),
      .idx    (idx_d),
      .node   (node_d),
      .link   (link_d)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_node  <= '0;
            rsp_link  <= '0;
            rsp_pair  <= '0;
         end else begin
            rsp_valid <= 1'b1;
            rsp_hit   <= any_d;
            rsp_miss  <= !any_d;
            rsp_node  <= node_d;
            rsp_link  <= link_d;
            rsp_pair  <= idx_d;
         end
      end

      // R11
      rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);

      // R11
      rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !rsp_valid);
   end else begin : g_comb_out
      assign rsp_valid = req_valid;
      assign rsp_hit   = req_valid && any_d;
      assign rsp_miss  = req_valid && !any_d;
      assign rsp_node  = req_valid ? node_d : '0;
      assign rsp_link  = req_valid ? link_d : '0;
      assign rsp_pair  = req_valid ? idx_d  : '0;
   end

   // R10
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (!rsp_hit && rsp_node == '0 && rsp_link == '0 && rsp_pair == '0));

endmodule

// File: tb/tb_io_space_router.sv
module tb_io_space_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [24:0] req_addr = '0;
   logic        rsp_valid, rsp_hit, rsp_miss;
   logic [2:0]  rsp_node;
   logic [1:0]  rsp_link;
   logic [1:0]  rsp_pair;

   int nchk = 0;
   int nfail = 0;
   string cur_tag = "R11";

   int mbase [4];
   int mlim  [4];
   bit  e_valid, e_hit, e_miss;
   int  e_node, e_link, e_pair;
   string e_tag = "R1";
   bit  cmp_on = 1'b0;

   always #2 clk = ~clk;

   io_space_router dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_node(rsp_node), .rsp_link(rsp_link), .rsp_pair(rsp_pair)
   );

   task automatic chk(string tag, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: decode one request against the model registers
   task automatic model_dec(input int a, input bit wr, output bit hit,
                            output int pair, output int node, output int link);
      hit = 0; pair = 0; node = 0; link = 0;
      for (int p = 0; p < 4; p++) begin
         bit ok, low, vga, blk, inr;
         int lo10, win;
         ok   = wr ? mbase[p][1] : mbase[p][0];
         low  = a < 32'h10000;
         lo10 = a % 1024;
         win  = a / 4096;
         vga  = mbase[p][4] && low &&
                ((lo10 >= 'h3B0 && lo10 <= 'h3BB) || (lo10 >= 'h3C0 && lo10 <= 'h3DF));
         blk  = mbase[p][5] && low && lo10 >= 256;
         inr  = win >= (mbase[p] / 4096) && win <= (mlim[p] / 4096);
         if (!hit && ok && (vga || (inr && !blk))) begin
            hit = 1; pair = p; node = mlim[p] % 8; link = (mlim[p] / 16) % 4;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         e_valid = 0; e_hit = 0; e_miss = 0; e_node = 0; e_link = 0; e_pair = 0;
         for (int p = 0; p < 4; p++) begin mbase[p] = 0; mlim[p] = 0; end
      end else begin
         bit h; int pr, nd, lk;
         model_dec(int'(req_addr), req_write, h, pr, nd, lk);
         e_tag   = cur_tag;
         e_valid = req_valid;
         e_hit   = req_valid && h;
         e_miss  = req_valid && !h;
         e_node  = req_valid ? nd : 0;
         e_link  = req_valid ? lk : 0;
         e_pair  = req_valid ? pr : 0;
         if (cfg_we) begin
            int p;
            p = int'(cfg_addr[2:1]);
            if (cfg_addr[0]) begin
               int nl;
               nl = (cfg_wdata[5:4] == 2'b11) ? ((mlim[p] / 16) % 4) : int'(cfg_wdata[5:4]);
               mlim[p] = int'(cfg_wdata & 32'h01FF_F007) | (nl * 16);
            end else begin
               mbase[p] = int'(cfg_wdata & 32'h01FF_F033);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R11", "rsp_valid", int'(rsp_valid), int'(e_valid));
         chk(e_tag, "rsp_hit",  int'(rsp_hit),  int'(e_hit));
         chk("R10", "rsp_miss", int'(rsp_miss), int'(e_miss));
         chk(e_tag, "rsp_node", int'(rsp_node), e_node);
         chk(e_tag, "rsp_link", int'(rsp_link), e_link);
         chk("R9",  "rsp_pair", int'(rsp_pair), e_pair);
      end
   end

   task automatic cfg_wr(int a, int d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic cfg_rd(string tag, int a, int exp);
      @(negedge clk);
      cfg_addr = 3'(a);
      #1;
      chk(tag, "cfg_rdata", int'(cfg_rdata), exp);
   endtask

   task automatic issue(string tag, int a, bit wr);
      @(negedge clk);
      cur_tag = tag; req_valid = 1; req_addr = 25'(a); req_write = wr;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 0; req_addr = '0; req_write = 0;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL all watchdog expired: actual running expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1: reset state
      chk("R1", "rsp_valid", int'(rsp_valid), 0);
      chk("R1", "rsp_hit", int'(rsp_hit), 0);
      for (int a = 0; a < 8; a++) cfg_rd("R1", a, 0);
      cmp_on = 1;
      issue("R1", 'h3C0, 0);
      idle(2);

      // R2: field layout and reserved bits
      cfg_wr(0, 32'hFFFF_FFFF);
      cfg_rd("R2", 0, 32'h01FF_F033);
      cfg_wr(1, 32'hFE00_0FE5);
      cfg_rd("R2", 1, 32'h0000_0025);
      // R3: reserved link code keeps previous link
      cfg_wr(1, 32'h0000_0033);
      cfg_rd("R3", 1, 32'h0000_0023);

      // R4: inclusive range compare, window 0x10..0x1F to node 1 link 1
      cfg_wr(1, 'h1F011);
      cfg_wr(0, 'h10003);
      issue("R4", 'h10000, 0);
      issue("R4", 'h1FFFF, 1);
      issue("R4", 'h1F000, 0);
      issue("R4", 'h20000, 0);
      issue("R4", 'h0FFFF, 0);
      idle(2);

      // R5: read-only window
      cfg_wr(3, 'h30022);
      cfg_wr(2, 'h30001);
      issue("R5", 'h30800, 0);
      issue("R5", 'h30800, 1);
      idle(2);

      // R6: display-adapter ports with an empty range
      cfg_wr(5, 'h00003);
      cfg_wr(4, 'h01013);
      issue("R6", 'h3B0, 0);
      issue("R6", 'h3BB, 1);
      issue("R6", 'h3BC, 0);
      issue("R6", 'h3C0, 0);
      issue("R6", 'h3DF, 0);
      issue("R6", 'h3E0, 0);
      issue("R6", 'h13C0, 0);
      issue("R6", 'h403C0, 0);
      idle(2);

      // R7: alias filter on window 0x000
      cfg_wr(7, 'h00004);
      cfg_wr(6, 'h00021);
      issue("R7", 'h050, 0);
      issue("R7", 'h150, 0);
      issue("R7", 'h3FF, 0);
      issue("R7", 'h400, 0);
      issue("R7", 'hBFF, 0);
      issue("R7", 'h800, 0);
      idle(2);

      // R8: filter does not block the adapter match
      cfg_wr(4, 0);
      cfg_wr(6, 'h00031);
      issue("R8", 'h3C5, 0);
      issue("R8", 'h3A0, 0);
      idle(2);

      // R9: overlapping windows, lowest index wins
      cfg_wr(3, 'h50016);
      cfg_wr(2, 'h10003);
      issue("R9", 'h18000, 0);
      idle(1);
      cfg_wr(0, 0);
      issue("R9", 'h18000, 0);
      idle(2);

      // R10: miss
      issue("R10", 'h1FF_FFFF, 0);
      issue("R10", 'h90000, 1);
      idle(3);

      // R11: write and request in the same cycle use old values
      @(negedge clk);
      cur_tag = "R11"; cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 'h10003;
      req_valid = 1; req_addr = 25'h18000; req_write = 0;
      @(negedge clk);
      cfg_we = 0;
      idle(3);

      summary();
      $finish;
   end

endmodule